// File: doc/BRIEF.md
# HDLC Data Link Message Transmitter

This block turns a short message held in an eight-entry byte buffer into a bit-serial HDLC frame for the terminal data link. The data link rides in the overhead bits of a line framer. The framer pulls one bit from the block on each cycle in which it raises `bit_en`. On other cycles the output holds its value. When no message is pending, the block sends the flag byte 0x7E over and over.

Software first writes the message bytes through a simple write port and sets `last_ptr` to the index of the final byte. It selects with `send_fcs` whether a CRC-16 check sequence follows the data, then pulses `send_msg`. The frame begins at the next flag boundary, so the idle flag that is in flight becomes the opening flag. `byte_irq` pulses each time a buffer byte is taken, and `done_irq` pulses once the closing flag is out. `abort_req` cuts a frame short: the block sends an unstuffed abort byte and then falls back to idle flags. `force_ones`, or a framing mode that carries no data link (`mode_dl_en` low), drives the line to all ones and discards any pending or active message.

The output side follows a pull model. `bit_en` plays the role of a ready strobe from the framer. The block always has a bit to offer and never stalls the framer, and the framer may hold `bit_en` low for any number of cycles without loss. `last_ptr`, `send_fcs` and the buffer contents must stay stable from `send_msg` until `done_irq` or an abort.

Top module: `dlink_tx`

## Requirements
- R1: After reset `tx_bit` is 1 and both interrupts are low. With no message pending, successive bits repeat the flag 0x7E LSB first (0,1,1,1,1,1,1,0), starting with a whole flag.
- R2: After a `send_msg` pulse, the next flag boundary is followed by buffer bytes 0 through `last_ptr`, each LSB first, then by a closing flag. `done_irq` is high for exactly one cycle, on the edge that drives the last bit of the closing flag, and idle flags follow.
- R3: In data and FCS bits, a 0 is inserted after every run of five consecutive 1s, including a run that ends the last byte before the closing flag. Flags and the abort byte are never stuffed.
- R4: With `send_fcs` high, the data is followed by 16 FCS bits in transmit order. These are the ones complement of a CRC computed over the data bits in transmit order, with reflected polynomial 0x8408 (x^16+x^12+x^5+1) and preset 0xFFFF. The bit-0 end is sent first. With `send_fcs` low, no FCS is sent.
- R5: `byte_irq` pulses once for each buffer byte loaded for sending, for a total of `last_ptr`+1 pulses per message, and never pulses outside a message.
- R6: `tx_bit` changes only on a clock edge at which `bit_en` is high. Otherwise it holds.
- R7: `abort_req` during data or FCS ends the frame at once. The next eight bits are 0x7F LSB first (seven 1s and then a 0), flags follow, and `done_irq` does not pulse.
- R8: While `force_ones` is high, every bit sent is 1 and `send_msg` and `abort_req` have no effect. The active message is dropped. After release, output resumes with a whole flag and no message.
- R9: While `mode_dl_en` is low, the block behaves exactly as in R8: all-ones output, and every control input is ignored.
- R10: A `wr_en` cycle stores `wr_data` at buffer entry `wr_addr`. The stored value is what a later message sends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_dl_en | input | 1 | High when the framing mode carries the data link |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | 3 | Buffer entry to write |
| wr_data | input | 8 | Byte to store |
| last_ptr | input | 3 | Index of the final message byte |
| send_msg | input | 1 | Pulse: start a message at the next flag boundary |
| send_fcs | input | 1 | Append the check sequence to the message |
| abort_req | input | 1 | Pulse: abort the frame in progress |
| force_ones | input | 1 | Force the line to all ones |
| bit_en | input | 1 | Framer takes one bit on this cycle |
| tx_bit | output | 1 | Serial data link output |
| byte_irq | output | 1 | One-cycle pulse per buffer byte taken |
| done_irq | output | 1 | One-cycle pulse when the closing flag has been sent |

## Verification
Every result in this block is due on the first clock edge that samples its cause. A bit appears on `tx_bit` on the edge where `bit_en` is high. `byte_irq` rises on the edge that shifts out the last bit of the preceding byte. `done_irq` rises with the final closing-flag bit. An abort or a disable takes effect on the very next edge, whether or not `bit_en` is high. The bench drives inputs and samples outputs on falling edges, so each reading follows exactly one rising edge after its stimulus. It compares the bit history against frames built in the bench from the requirements, and it spaces `bit_en` irregularly so that the hold behaviour is checked on every idle cycle.

// File: rtl/dl_pkg.sv
`timescale 1ns/1ps
package dl_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W = 16;
  localparam int RUN_LEN = 5;
  localparam logic [BYTE_W-1:0] FLAG_BYTE = 8'h7E;
  localparam logic [BYTE_W-1:0] ABORT_BYTE = 8'h7F;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 16'h8408;
  localparam logic [CRC_W-1:0] CRC_PRESET = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_FCSL,
    ST_FCSH,
    ST_CLOSE,
    ST_ABORT
  } dl_state_e;
endpackage

// File: rtl/dlink_crc.sv
`timescale 1ns/1ps
module dlink_crc #(
  parameter int W = 16,
  parameter logic [W-1:0] POLY = 16'h8408,
  parameter logic [W-1:0] PRESET = 16'hFFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic         bit_in,
  output logic [W-1:0] crc_q,
  output logic [W-1:0] crc_nx
);
  logic fb;
  assign fb = crc_q[0] ^ bit_in;

  always_comb begin
    crc_nx = crc_q;
    if (step) crc_nx = (crc_q >> 1) ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   crc_q <= PRESET;
    else if (clr) crc_q <= PRESET;
    else          crc_q <= crc_nx;
  end

  // R4
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !step) |=> $stable(crc_q));
endmodule

// File: rtl/dlink_stuff.sv
`timescale 1ns/1ps
module dlink_stuff #(
  parameter int RUN = 5,
  localparam int OW = $clog2(RUN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  input  logic bit_val,
  input  logic count_en,
  output logic stuff_now
);
  logic [OW-1:0] ones_q;

  assign stuff_now = (ones_q == OW'(RUN));

  always_ff @(posedge clk) begin
    if (!rst_n)        ones_q <= '0;
    else if (clr)      ones_q <= '0;
    else if (adv) begin
      if (stuff_now)   ones_q <= '0;
      else if (count_en && bit_val) ones_q <= ones_q + 1'b1;
      else             ones_q <= '0;
    end
  end

  // R3
  run_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= OW'(RUN));

  // R3
  stuff_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && stuff_now && !clr) |=> (ones_q == '0));
endmodule

// File: rtl/dlink_tx.sv
`timescale 1ns/1ps
module dlink_tx #(
  parameter int BUF_DEPTH = 8,
  localparam int PTR_W = $clog2(BUF_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_dl_en,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [PTR_W-1:0] last_ptr,
  input  logic             send_msg,
  input  logic             send_fcs,
  input  logic             abort_req,
  input  logic             force_ones,
  input  logic             bit_en,
  output logic             tx_bit,
  output logic             byte_irq,
  output logic             done_irq
);
  import dl_pkg::*;
  localparam int CNT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] msg_mem [BUF_DEPTH];
  dl_state_e         st_q, nx_st;
  logic [BYTE_W-1:0] sh_q, nx_sh;
  logic [CNT_W-1:0]  cnt_q;
  logic [PTR_W-1:0]  idx_q, nx_idx;
  logic              go_q, tx_q, byte_irq_q, done_irq_q;
  logic              hit_byte, hit_done;
  logic [CRC_W-1:0]  crc_q, crc_nx;

  // buffer entries, one register per slot
  for (genvar gi = 0; gi < BUF_DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && wr_addr == PTR_W'(gi)) msg_mem[gi] <= wr_data;
    end
  end

  logic dis, in_msg, do_abort, adv, shift, byte_end, stuff_now;
  assign dis      = force_ones | ~mode_dl_en;
  assign in_msg   = (st_q == ST_DATA) || (st_q == ST_FCSL) || (st_q == ST_FCSH);
  assign do_abort = ~dis & abort_req & in_msg;
  assign adv      = ~dis & ~do_abort & bit_en;
  assign shift    = adv & ~stuff_now;
  assign byte_end = shift & (cnt_q == CNT_W'(BYTE_W - 1));

  dlink_crc #(.W(CRC_W), .POLY(CRC_POLY_REFL), .PRESET(CRC_PRESET)) crc_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (byte_end && st_q == ST_IDLE && go_q),
    .step   (shift && st_q == ST_DATA),
    .bit_in (sh_q[0]),
    .crc_q  (crc_q),
    .crc_nx (crc_nx)
  );

  dlink_stuff #(.RUN(RUN_LEN)) stuff_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (dis | do_abort),
    .adv       (adv),
    .bit_val   (sh_q[0]),
    .count_en  (in_msg),
    .stuff_now (stuff_now)
  );

  // what to load at the end of the byte now leaving the shifter
  always_comb begin
    nx_st    = st_q;
    nx_sh    = FLAG_BYTE;
    nx_idx   = idx_q;
    hit_byte = 1'b0;
    hit_done = 1'b0;
    unique case (st_q)
      ST_IDLE: if (go_q) begin
        nx_st    = ST_DATA;
        nx_idx   = '0;
        nx_sh    = msg_mem[0];
        hit_byte = 1'b1;
      end
      ST_DATA: if (idx_q == last_ptr) begin
        if (send_fcs) begin
          nx_st = ST_FCSL;
          nx_sh = ~crc_nx[7:0];
        end else begin
          nx_st = ST_CLOSE;
        end
      end else begin
        nx_idx   = idx_q + 1'b1;
        nx_sh    = msg_mem[nx_idx];
        hit_byte = 1'b1;
      end
      ST_FCSL: begin
        nx_st = ST_FCSH;
        nx_sh = ~crc_q[15:8];
      end
      ST_FCSH: nx_st = ST_CLOSE;
      ST_CLOSE: begin
        nx_st    = ST_IDLE;
        hit_done = 1'b1;
      end
      default: nx_st = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      sh_q       <= FLAG_BYTE;
      cnt_q      <= '0;
      idx_q      <= '0;
      go_q       <= 1'b0;
      tx_q       <= 1'b1;
      byte_irq_q <= 1'b0;
      done_irq_q <= 1'b0;
    end else begin
      byte_irq_q <= 1'b0;
      done_irq_q <= 1'b0;
      if (dis) begin
        st_q  <= ST_IDLE;
        sh_q  <= FLAG_BYTE;
        cnt_q <= '0;
        go_q  <= 1'b0;
        if (bit_en) tx_q <= 1'b1;
      end else if (do_abort) begin
        st_q  <= ST_ABORT;
        sh_q  <= ABORT_BYTE;
        cnt_q <= '0;
        go_q  <= 1'b0;
      end else begin
        if (send_msg && st_q == ST_IDLE) go_q <= 1'b1;
        if (adv) begin
          if (stuff_now) begin
            tx_q <= 1'b0;
          end else begin
            tx_q  <= sh_q[0];
            cnt_q <= cnt_q + 1'b1;
            if (byte_end) begin
              st_q       <= nx_st;
              sh_q       <= nx_sh;
              idx_q      <= nx_idx;
              byte_irq_q <= hit_byte;
              done_irq_q <= hit_done;
              if (st_q == ST_IDLE && go_q) go_q <= 1'b0;
            end else begin
              sh_q <= {1'b0, sh_q[BYTE_W-1:1]};
            end
          end
        end
      end
    end
  end

  assign tx_bit   = tx_q;
  assign byte_irq = byte_irq_q;
  assign done_irq = done_irq_q;

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit));

  // R8
  dis_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && (force_ones || !mode_dl_en)) |=> tx_bit);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  // R5
  byte_in_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_irq |-> (st_q == ST_DATA));

  // R7
  abort_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_req && in_msg && !force_ones && mode_dl_en) |=> (st_q == ST_ABORT && !done_irq && !byte_irq));
endmodule

// File: tb/dlink_tx_tb.sv
`timescale 1ns/1ps
module dlink_tx_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0, mode_dl_en = 1'b1, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, last_ptr = '0;
  logic [7:0] wr_data = '0;
  logic       send_msg = 1'b0, send_fcs = 1'b0, abort_req = 1'b0;
  logic       force_ones = 1'b0, bit_en = 1'b0;
  logic       tx_bit, byte_irq, done_irq;

  dlink_tx dut_i (
    .clk(clk), .rst_n(rst_n), .mode_dl_en(mode_dl_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .last_ptr(last_ptr),
    .send_msg(send_msg), .send_fcs(send_fcs), .abort_req(abort_req),
    .force_ones(force_ones), .bit_en(bit_en), .tx_bit(tx_bit),
    .byte_irq(byte_irq), .done_irq(done_irq)
  );

  // {last index, fcs on, bytes 7..0}
  localparam logic [67:0] VECS [5] = '{
    {3'd0, 1'b1, 64'h0000_0000_0000_00C3},
    {3'd7, 1'b1, 64'h0807_0605_0403_0201},
    {3'd3, 1'b0, 64'h0000_0000_FFFF_FFFF},
    {3'd2, 1'b1, 64'h0000_0000_001F_3E7E},
    {3'd7, 1'b0, 64'hA5F0_FF7E_0F81_C3FF}
  };

  int   n_chk = 0, n_fail = 0, byte_seen = 0, done_seen = 0;
  bit   hist[$];
  bit   exp_q[$];
  logic last_tx;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input bit be);
    bit_en = be;
    @(posedge clk);
    @(negedge clk);
    bit_en = 1'b0;
    if (byte_irq) byte_seen++;
    if (done_irq) done_seen++;
    if (be) hist.push_back(tx_bit);
    else chk(tx_bit === last_tx, "R6", "hold without bit_en", int'(tx_bit), int'(last_tx));
    last_tx = tx_bit;
  endtask

  task automatic push_flag();
    for (int i = 0; i < 8; i++) exp_q.push_back(i != 0 && i != 7);
  endtask

  task automatic build_frame(input logic [63:0] d, input int last, input bit fcs);
    bit body[$];
    logic [15:0] crc = 16'hFFFF;
    logic [15:0] f;
    int ones = 0;
    for (int i = 0; i <= last; i++)
      for (int b = 0; b < 8; b++) begin
        bit v = d[8*i+b];
        bit fb = crc[0] ^ v;
        body.push_back(v);
        crc = crc >> 1;
        if (fb) crc = crc ^ 16'h8408;
      end
    if (fcs) begin
      f = ~crc;
      for (int b = 0; b < 16; b++) body.push_back(f[b]);
    end
    exp_q.delete();
    push_flag();
    foreach (body[i]) begin
      exp_q.push_back(body[i]);
      ones = body[i] ? ones + 1 : 0;
      if (ones == 5) begin
        exp_q.push_back(1'b0);
        ones = 0;
      end
    end
    push_flag();
  endtask

  task automatic chk_window(input int base, input string req, input string what);
    int bad = -1;
    if (hist.size() < base + exp_q.size()) bad = 0;
    else foreach (exp_q[i]) if (bad < 0 && hist[base+i] !== exp_q[i]) bad = i;
    chk(bad < 0, req, what, bad < 0 ? 0 : int'(hist[base+bad]),
        bad < 0 ? 0 : int'(exp_q[bad]));
  endtask

  task automatic load_buf(input logic [63:0] d);
    for (int i = 0; i < 8; i++) begin
      wr_en = 1'b1; wr_addr = 3'(i); wr_data = d[8*i+:8];
      tick(0);
    end
    wr_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(tx_bit === 1'b1, "R1", "tx_bit after reset", int'(tx_bit), 1);
    chk(byte_irq === 1'b0 && done_irq === 1'b0, "R1", "irqs after reset",
        int'({byte_irq, done_irq}), 0);
    last_tx = tx_bit;
    exp_q.delete(); push_flag(); push_flag();
    base = hist.size();
    repeat (16) tick(1);
    chk_window(base, "R1", "idle flags");

    // table walk: R2 R3 R4 R5 R10
    foreach (VECS[v]) begin
      int k = 0;
      load_buf(VECS[v][63:0]);
      last_ptr = VECS[v][67:65];
      send_fcs = VECS[v][64];
      build_frame(VECS[v][63:0], int'(VECS[v][67:65]), VECS[v][64]);
      repeat (3) tick(1);
      byte_seen = 0; done_seen = 0;
      send_msg = 1'b1; tick(0); send_msg = 1'b0;
      while (done_seen == 0 && k < 900) begin
        tick((k % 3) != 2);
        k++;
      end
      chk_window(hist.size() - exp_q.size(), "R2/R3/R4/R10", "frame bits");
      chk(byte_seen == int'(VECS[v][67:65]) + 1, "R5", "byte_irq count",
          byte_seen, int'(VECS[v][67:65]) + 1);
      chk(done_seen == 1, "R2", "done_irq count", done_seen, 1);
    end

    // R7 abort mid-data
    load_buf(64'h5555_5555_5555_5555);
    last_ptr = 3'd7; send_fcs = 1'b0;
    send_msg = 1'b1; tick(0); send_msg = 1'b0;
    repeat (40) tick(1);
    done_seen = 0;
    abort_req = 1'b1; tick(0); abort_req = 1'b0;
    exp_q.delete();
    for (int i = 0; i < 8; i++) exp_q.push_back(i != 7);
    push_flag(); push_flag();
    base = hist.size();
    repeat (24) tick(1);
    chk_window(base, "R7", "abort byte then flags");
    chk(done_seen == 0, "R7", "no done after abort", done_seen, 0);

    // R8 forced ones, send ignored
    load_buf(64'h0);
    byte_seen = 0;
    force_ones = 1'b1; send_msg = 1'b1; tick(0); send_msg = 1'b0;
    exp_q.delete();
    for (int i = 0; i < 12; i++) exp_q.push_back(1'b1);
    base = hist.size();
    repeat (12) tick(1);
    chk_window(base, "R8", "all ones while forced");
    force_ones = 1'b0; tick(0);
    exp_q.delete(); push_flag(); push_flag(); push_flag();
    base = hist.size();
    repeat (24) tick(1);
    chk_window(base, "R8", "flags after release");
    chk(byte_seen == 0, "R8", "send_msg ignored", byte_seen, 0);

    // R9 mode without data link
    mode_dl_en = 1'b0; send_msg = 1'b1; abort_req = 1'b1; tick(0);
    send_msg = 1'b0; abort_req = 1'b0;
    exp_q.delete();
    for (int i = 0; i < 10; i++) exp_q.push_back(1'b1);
    base = hist.size();
    repeat (10) tick(1);
    chk_window(base, "R9", "all ones without link");
    mode_dl_en = 1'b1; tick(0);
    exp_q.delete(); push_flag(); push_flag();
    base = hist.size();
    repeat (16) tick(1);
    chk_window(base, "R9", "flags after mode restored");
    chk(byte_seen == 0 && done_seen == 0, "R9", "controls ignored",
        byte_seen + done_seen, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule